// File: doc/BRIEF.md
# AUX Request Framer and Reply Decoder

This block turns one DisplayPort AUX request into the byte stream that a link transport sends, runs that single transaction, and turns the transport's answer into a result for the requester. The requester gives a 20-bit address, a 4-bit request code, a payload length and up to sixteen payload bytes. The block first checks the request. A request that is too long or has a code the block does not know finishes at once with an error class, and nothing is sent.

An accepted request goes out as a fixed four-byte header. For write-type requests the payload follows the header. The bytes are sent one at a time over a valid/ready stream, and `txLast` marks the final byte. The block then waits for one response beat. That beat carries a status byte, an acknowledge byte, a received-byte count and up to sixteen received bytes. The status is decoded into timeout, two I/O error classes or success. On success the block reports the sink reply code and the number of bytes delivered. Received data is returned only for reads, clipped to the length that was asked for.

Only one request can be in flight. `reqReady` stays low from acceptance until the result has been presented.

Top module: `aux_request_builder`

## Requirements
- R1: Sent byte 0 is address bits 7:0. Byte 1 is address bits 15:8. Byte 2 carries the request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Bits 3:0 of sent byte 3 hold the length minus one. They hold 0 when the length is 0.
- R3: Bits 7:4 of sent byte 3 hold 3 for a zero-length request. Otherwise a read holds 4, and a write holds the low four bits of 4 plus the length, so a 12-byte write gives 0.
- R4: A write sends 4 + length bytes, with payload byte i taken from `reqData[8i+7:8i]` in ascending order. A read sends only the 4 header bytes.
- R5: The check ignores bit 2 of the code. A length above 16 on any request gives result 4 (too big), and so does a write longer than 12 bytes. The length check above 16 is made before the code check. Such a request sends no byte.
- R6: After bit 2 is cleared, codes 0x0, 0x2 and 0x8 are writes and codes 0x1 and 0x9 are reads. Any other code, with a length of at most 16, gives result 5 (bad code) and sends nothing.
- R7: A response status of 1 gives result 1 (timeout), 2 gives result 2 and 3 gives result 3. Any other status gives result 0 (success). On results 1 to 3 the count, reply and data are all zero.
- R8: On success `doneReply` equals bits 7:4 of the acknowledge byte.
- R9: On a successful write `doneCount` equals the requested length and `doneData` is zero. On a successful read `doneCount` is the smaller of `rspCount` and the requested length. Bytes of `doneData` at or above that count are zero.
- R10: `doneValid` is high for exactly one cycle. `reqReady` is low from acceptance until the cycle after `doneValid`. A request presented while busy is ignored.
- R11: While `txValid` is high and `txReady` is low, `txValid` and `txByte` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can accept a request |
| reqCode | input | 4 | Request code; bit 2 is the I2C middle-of-transaction flag |
| reqAddr | input | 20 | Target address |
| reqLen | input | 5 | Payload or read length in bytes |
| reqData | input | 128 | Write payload, byte i at bits 8i+7:8i |
| busy | output | 1 | A transaction is in progress |
| txValid | output | 1 | Outgoing byte valid |
| txReady | input | 1 | Transport takes the byte |
| txByte | output | 8 | Outgoing byte |
| txLast | output | 1 | Current byte is the final one |
| rspValid | input | 1 | Response beat valid |
| rspReady | output | 1 | Block is waiting for the response |
| rspStatus | input | 8 | Transport status byte |
| rspAck | input | 8 | Acknowledge byte; reply code in bits 7:4 |
| rspCount | input | 5 | Bytes the sink returned |
| rspData | input | 128 | Returned bytes, byte i at bits 8i+7:8i |
| doneValid | output | 1 | Result presented (one cycle) |
| doneResult | output | 3 | 0 ok, 1 timeout, 2 flags error, 3 general error, 4 too big, 5 bad code |
| doneCount | output | 5 | Reported byte count |
| doneReply | output | 4 | Sink reply code |
| doneData | output | 128 | Delivered read bytes |

## Verification
The framing is tried on:
- native and I2C writes of 0, 5 and 12 bytes, which separates the bare-address count value, the ordinary total and the wrapped total;
- reads of 0, 4, 8 and 16 bytes, which shows that the read header never grows with the length;
- the middle-of-transaction codes, which show that bit 2 plays no part in classification.

Response beats that return more bytes than were asked for and fewer bytes than were asked for show which way the count is clipped. The status values 1, 2, 3 and 7 separate the three error classes from success. The rejections include a 13-byte write, a 17-byte read, an unknown code and an unknown code with an oversize length; the last shows which check wins. One run stalls the transport on alternate cycles to expose any byte that moves while held. Another keeps offering a request the whole time the block is busy.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;

  localparam int HDR_BYTES  = 4;
  localparam int BARE_COUNT = HDR_BYTES - 1;
  localparam int MOT_BIT    = 2;

  localparam logic [3:0] CODE_I2C_WR  = 4'h0;
  localparam logic [3:0] CODE_I2C_RD  = 4'h1;
  localparam logic [3:0] CODE_I2C_WSU = 4'h2;
  localparam logic [3:0] CODE_NAT_WR  = 4'h8;
  localparam logic [3:0] CODE_NAT_RD  = 4'h9;

  localparam logic [7:0] ST_TIMEOUT = 8'd1;
  localparam logic [7:0] ST_FLAGS   = 8'd2;
  localparam logic [7:0] ST_FAULT   = 8'd3;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_TIMEOUT  = 3'd1,
    RES_FLAGS    = 3'd2,
    RES_FAULT    = 3'd3,
    RES_TOO_BIG  = 3'd4,
    RES_BAD_CODE = 3'd5
  } resKind_t;

  typedef struct packed {
    logic latch;
    logic shift;
    logic capture;
  } ctrlStrobe_t;

endpackage

// File: rtl/aux_req_ctrl.sv
module aux_req_ctrl
  import aux_req_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  resKind_t    verdict,
  input  logic        txReady,
  input  logic        txLast,
  input  logic        rspValid,
  output logic        reqReady,
  output logic        busy,
  output logic        txValid,
  output logic        rspReady,
  output logic        doneValid,
  output ctrlStrobe_t strobe
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_DONE} state_t;

  state_t stateQ, stateD;

  always_comb begin
    strobe         = '0;
    stateD         = stateQ;
    strobe.latch   = (stateQ == S_IDLE) && reqValid;
    strobe.shift   = (stateQ == S_SEND) && txReady;
    strobe.capture = (stateQ == S_WAIT) && rspValid;
    unique case (stateQ)
      S_IDLE: if (reqValid) stateD = (verdict == RES_OK) ? S_SEND : S_DONE;
      S_SEND: if (txReady && txLast) stateD = S_WAIT;
      S_WAIT: if (rspValid) stateD = S_DONE;
      S_DONE: stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign busy      = (stateQ != S_IDLE);
  assign reqReady  = (stateQ == S_IDLE);
  assign txValid   = (stateQ == S_SEND);
  assign rspReady  = (stateQ == S_WAIT);
  assign doneValid = (stateQ == S_DONE);

  // R10: result shown for one cycle, then a new request is accepted
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && reqReady);

  // R5, R6: a refused request finishes without sending
  a_r5_reject_silent: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latch && verdict != RES_OK) |=> (doneValid && !txValid));

endmodule

// File: rtl/aux_req_dpath.sv
module aux_req_dpath
  import aux_req_pkg::*;
#(
  parameter  int MAX_PAYLOAD = 16,
  parameter  int MAX_WRITE   = 12,
  localparam int LEN_W       = $clog2(MAX_PAYLOAD + 1),
  localparam int DATA_W      = 8 * MAX_PAYLOAD
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [3:0]        reqCode,
  input  logic [19:0]       reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [DATA_W-1:0] reqData,
  input  logic [7:0]        rspStatus,
  input  logic [7:0]        rspAck,
  input  logic [LEN_W-1:0]  rspCount,
  input  logic [DATA_W-1:0] rspData,
  output resKind_t          verdict,
  output logic [7:0]        txByte,
  output logic              txLast,
  output resKind_t          resKind,
  output logic [LEN_W-1:0]  resCount,
  output logic [3:0]        resReply,
  output logic [DATA_W-1:0] resData
);

  localparam int FRAME_BYTES = HDR_BYTES + MAX_PAYLOAD;
  localparam int IDX_W       = $clog2(FRAME_BYTES + 1);
  localparam int FRAME_SLOTS = 1 << IDX_W;

  // request classification
  logic [3:0] baseCode;
  logic       isWrCode, isRdCode;

  always_comb begin
    baseCode          = reqCode;
    baseCode[MOT_BIT] = 1'b0;
    isWrCode = (baseCode == CODE_I2C_WR) || (baseCode == CODE_I2C_WSU) ||
               (baseCode == CODE_NAT_WR);
    isRdCode = (baseCode == CODE_I2C_RD) || (baseCode == CODE_NAT_RD);
  end

  always_comb begin
    if (int'(reqLen) > MAX_PAYLOAD)              verdict = RES_TOO_BIG;
    else if (!(isWrCode || isRdCode))            verdict = RES_BAD_CODE;
    else if (isWrCode && int'(reqLen) > MAX_WRITE) verdict = RES_TOO_BIG;
    else                                         verdict = RES_OK;
  end

  // header nibbles
  logic [LEN_W:0] sumCount;
  logic [3:0]     lenNib, cntNib;

  assign sumCount = (LEN_W+1)'(HDR_BYTES) + {1'b0, reqLen};

  always_comb begin
    lenNib = (reqLen == '0) ? 4'd0 : 4'(reqLen - 1'b1);
    if (reqLen == '0)  cntNib = 4'(BARE_COUNT);
    else if (isWrCode) cntNib = sumCount[3:0];
    else               cntNib = 4'(HDR_BYTES);
  end

  // payload byte lanes
  logic [7:0] payByte [MAX_PAYLOAD];
  for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_unpack
    assign payByte[g] = reqData[8*g +: 8];
  end

  // outgoing frame store and byte pointer
  logic [7:0]       frameQ [FRAME_SLOTS];
  logic [IDX_W-1:0] idxQ, txLenQ;
  logic             isWrQ;
  logic [LEN_W-1:0] lenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FRAME_SLOTS; i++) frameQ[i] <= '0;
    end else if (strobe.latch) begin
      frameQ[0] <= reqAddr[7:0];
      frameQ[1] <= reqAddr[15:8];
      frameQ[2] <= {reqCode, reqAddr[19:16]};
      frameQ[3] <= {cntNib, lenNib};
      for (int i = 0; i < MAX_PAYLOAD; i++) frameQ[HDR_BYTES+i] <= payByte[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ   <= '0;
      txLenQ <= '0;
      isWrQ  <= 1'b0;
      lenQ   <= '0;
    end else if (strobe.latch) begin
      idxQ   <= '0;
      txLenQ <= isWrCode ? IDX_W'(HDR_BYTES) + IDX_W'(reqLen) : IDX_W'(HDR_BYTES);
      isWrQ  <= isWrCode;
      lenQ   <= reqLen;
    end else if (strobe.shift) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  assign txByte = frameQ[idxQ];
  assign txLast = (idxQ == txLenQ - 1'b1);

  // reply decode
  logic [LEN_W-1:0]  clipCnt;
  logic [DATA_W-1:0] rxKeep;

  assign clipCnt = (rspCount < lenQ) ? rspCount : lenQ;

  for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_rxmask
    assign rxKeep[8*g +: 8] = (!isWrQ && (LEN_W'(g) < clipCnt)) ? rspData[8*g +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resKind  <= RES_OK;
      resCount <= '0;
      resReply <= '0;
      resData  <= '0;
    end else if (strobe.latch) begin
      resKind  <= verdict;
      resCount <= '0;
      resReply <= '0;
      resData  <= '0;
    end else if (strobe.capture) begin
      resCount <= '0;
      resReply <= '0;
      resData  <= '0;
      case (rspStatus)
        ST_TIMEOUT: resKind <= RES_TIMEOUT;
        ST_FLAGS:   resKind <= RES_FLAGS;
        ST_FAULT:   resKind <= RES_FAULT;
        default: begin
          resKind  <= RES_OK;
          resReply <= rspAck[7:4];
          resCount <= isWrQ ? lenQ : clipCnt;
          resData  <= rxKeep;
        end
      endcase
    end
  end

  // R9: reported count never exceeds the requested length
  a_r9_count_clip: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> resCount <= lenQ);

  // R7: error statuses carry no count, reply or data
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && (rspStatus == ST_TIMEOUT || rspStatus == ST_FLAGS ||
                        rspStatus == ST_FAULT))
    |=> (resCount == '0 && resReply == '0 && resData == '0));

  // R4: a read ends after the header
  a_r4_read_header_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift && txLast && !isWrQ) |-> idxQ == IDX_W'(HDR_BYTES - 1));

endmodule

// File: rtl/aux_request_builder.sv
module aux_request_builder
  import aux_req_pkg::*;
#(
  parameter  int MAX_PAYLOAD = 16,
  parameter  int MAX_WRITE   = 12,
  localparam int LEN_W       = $clog2(MAX_PAYLOAD + 1),
  localparam int DATA_W      = 8 * MAX_PAYLOAD
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        reqCode,
  input  logic [19:0]       reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txByte,
  output logic              txLast,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [7:0]        rspStatus,
  input  logic [7:0]        rspAck,
  input  logic [LEN_W-1:0]  rspCount,
  input  logic [DATA_W-1:0] rspData,
  output logic              doneValid,
  output logic [2:0]        doneResult,
  output logic [LEN_W-1:0]  doneCount,
  output logic [3:0]        doneReply,
  output logic [DATA_W-1:0] doneData
);

  ctrlStrobe_t strobe;
  resKind_t    verdict, resKind;

  aux_req_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .verdict  (verdict),
    .txReady  (txReady),
    .txLast   (txLast),
    .rspValid (rspValid),
    .reqReady (reqReady),
    .busy     (busy),
    .txValid  (txValid),
    .rspReady (rspReady),
    .doneValid(doneValid),
    .strobe   (strobe)
  );

  aux_req_dpath #(.MAX_PAYLOAD(MAX_PAYLOAD), .MAX_WRITE(MAX_WRITE)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqCode  (reqCode),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .reqData  (reqData),
    .rspStatus(rspStatus),
    .rspAck   (rspAck),
    .rspCount (rspCount),
    .rspData  (rspData),
    .verdict  (verdict),
    .txByte   (txByte),
    .txLast   (txLast),
    .resKind  (resKind),
    .resCount (doneCount),
    .resReply (doneReply),
    .resData  (doneData)
  );

  assign doneResult = resKind;

  // R11: a stalled byte holds
  a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte)));

endmodule

// File: tb/test_aux_request_builder.sv
module test_aux_request_builder;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [3:0]   reqCode = '0;
  logic [19:0]  reqAddr = '0;
  logic [4:0]   reqLen = '0;
  logic [127:0] reqData = '0;
  logic         busy;
  logic         txValid;
  logic         txReady = 1'b0;
  logic [7:0]   txByte;
  logic         txLast;
  logic         rspValid = 1'b0;
  logic         rspReady;
  logic [7:0]   rspStatus = '0;
  logic [7:0]   rspAck = '0;
  logic [4:0]   rspCount = '0;
  logic [127:0] rspData = '0;
  logic         doneValid;
  logic [2:0]   doneResult;
  logic [4:0]   doneCount;
  logic [3:0]   doneReply;
  logic [127:0] doneData;

  int vectors = 0;
  int fails   = 0;

  logic [7:0]   gotBytes [32];
  int           gotN;
  bit           gotDone, holdBad, pokeBad;
  logic [2:0]   gotKind;
  logic [4:0]   gotCount;
  logic [3:0]   gotReply;
  logic [127:0] gotData;

  always #10 clk = ~clk;

  aux_request_builder i_aux_request_builder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCode(reqCode), .reqAddr(reqAddr), .reqLen(reqLen), .reqData(reqData),
    .busy(busy), .txValid(txValid), .txReady(txReady), .txByte(txByte),
    .txLast(txLast), .rspValid(rspValid), .rspReady(rspReady),
    .rspStatus(rspStatus), .rspAck(rspAck), .rspCount(rspCount),
    .rspData(rspData), .doneValid(doneValid), .doneResult(doneResult),
    .doneCount(doneCount), .doneReply(doneReply), .doneData(doneData)
  );

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runReq(input logic [3:0] code, input logic [19:0] addr, input int len,
                        input logic [127:0] data, input bit stall, input bit poke);
    bit rspSent = 0, havePrev = 0;
    logic [7:0] prevByte = '0;
    for (int i = 0; i < 32; i++) gotBytes[i] = '0;
    gotN = 0; gotDone = 0; holdBad = 0; pokeBad = 0;
    @(negedge clk);
    reqCode = code; reqAddr = addr; reqLen = 5'(len); reqData = data; reqValid = 1'b1;
    @(negedge clk);
    reqValid = poke;
    if (poke) begin reqCode = 4'hA; reqLen = 5'd1; reqAddr = ~addr; end
    for (int cyc = 0; cyc < 300 && !gotDone; cyc++) begin
      rspValid = 1'b0;
      txReady  = stall ? (cyc % 2 == 1) : 1'b1;
      if (rspReady && !rspSent) begin rspValid = 1'b1; rspSent = 1; end
      #1;
      if (poke && reqReady) pokeBad = 1;
      if (havePrev && (!txValid || txByte !== prevByte)) holdBad = 1;
      havePrev = txValid && !txReady;
      prevByte = txByte;
      if (txValid && txReady && gotN < 32) begin gotBytes[gotN] = txByte; gotN++; end
      if (doneValid) begin
        gotDone = 1; gotKind = doneResult; gotCount = doneCount;
        gotReply = doneReply; gotData = doneData; reqValid = 1'b0;
      end else @(negedge clk);
    end
    rspValid = 1'b0;
    check("R10", "transaction completed", 128'(gotDone), 128'd1);
    @(negedge clk);
    check("R10", "done pulse ends and ready returns", {doneValid, reqReady}, 128'b01);
    if (poke) begin
      check("R10", "ready low while busy", 128'(pokeBad), 128'd0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R10", "request offered while busy left no trace",
              {txValid, doneValid}, 128'b00);
      end
    end
  endtask

  task automatic doTxn(input string name, input logic [3:0] code, input logic [19:0] addr,
                       input int len, input logic [127:0] data, input bit stall,
                       input logic [7:0] st, input logic [7:0] ack, input int rcnt,
                       input logic [127:0] rdata, input bit poke);
    logic [3:0] base, hiNib, loNib;
    bit isW, isR;
    int expKind, expCnt, expN;
    logic [127:0] expPay, gotPay, expData;
    rspStatus = st; rspAck = ack; rspCount = 5'(rcnt); rspData = rdata;
    runReq(code, addr, len, data, stall, poke);
    base = code; base[2] = 1'b0;
    isW = (base == 4'h0) || (base == 4'h2) || (base == 4'h8);
    isR = (base == 4'h1) || (base == 4'h9);
    if (len > 16) expKind = 4;
    else if (!(isW || isR)) expKind = 5;
    else if (isW && len > 12) expKind = 4;
    else if (st == 1 || st == 2 || st == 3) expKind = int'(st);
    else expKind = 0;
    $display("-- %s", name);
    if (expKind == 4) check("R5", "too big result / nothing sent", {gotKind, 5'(gotN)}, {3'd4, 5'd0});
    else if (expKind == 5) check("R6", "bad code result / nothing sent", {gotKind, 5'(gotN)}, {3'd5, 5'd0});
    else begin
      expN  = isW ? 4 + len : 4;
      loNib = (len == 0) ? 4'd0 : 4'(len - 1);
      hiNib = (len == 0) ? 4'd3 : (isW ? 4'((4 + len) % 16) : 4'd4);
      check("R1", "header bytes 0..2", {gotBytes[0], gotBytes[1], gotBytes[2]},
            {addr[7:0], addr[15:8], code, addr[19:16]});
      check("R2", "byte 3 length nibble", 128'(gotBytes[3][3:0]), 128'(loNib));
      check("R3", "byte 3 count nibble", 128'(gotBytes[3][7:4]), 128'(hiNib));
      check("R4", "bytes sent", 128'(gotN), 128'(expN));
      if (isW && len > 0) begin
        expPay = '0; gotPay = '0;
        for (int i = 0; i < len; i++) begin
          expPay[8*i +: 8] = data[8*i +: 8];
          gotPay[8*i +: 8] = gotBytes[4+i];
        end
        check("R4", "payload order", gotPay, expPay);
      end
      check("R7", "status decode", 128'(gotKind), 128'(expKind));
      if (stall) check("R11", "stalled byte held", 128'(holdBad), 128'd0);
    end
    expCnt = 0; expData = '0;
    if (expKind == 0) begin
      expCnt = isW ? len : ((rcnt < len) ? rcnt : len);
      if (isR) for (int i = 0; i < expCnt; i++) expData[8*i +: 8] = rdata[8*i +: 8];
    end
    check("R9", "count", 128'(gotCount), 128'(expCnt));
    check("R8", "reply code", 128'(gotReply), (expKind == 0) ? 128'(ack[7:4]) : 128'd0);
    check("R9", "delivered data", gotData, expData);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [127:0] pat, rpat;
    pat  = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
    rpat = 128'hA1B2C3D4E5F60718293A4B5C6D7E8F90;
    repeat (3) @(negedge clk);
    check("R10", "reset state ready/busy/tx/done", {reqReady, busy, txValid, doneValid}, 128'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "idle after reset", {reqReady, busy, txValid, doneValid}, 128'b1000);

    doTxn("native write 5", 4'h8, 20'h5A3C1, 5, pat, 0, 8'h00, 8'h00, 0, '0, 0);
    doTxn("i2c write mot addr-only", 4'h4, 20'hFEDCB, 0, pat, 1, 8'h00, 8'h40, 0, '0, 0);
    doTxn("status-update write 12 stalled", 4'h2, 20'h00123, 12, pat, 1, 8'h00, 8'h20, 0, '0, 0);
    doTxn("native write 11", 4'hC, 20'h80001, 11, pat, 0, 8'h00, 8'h00, 0, '0, 0);
    doTxn("native read 16", 4'h9, 20'h00200, 16, '0, 0, 8'h00, 8'h10, 16, rpat, 0);
    doTxn("i2c read mot clipped", 4'h5, 20'h00050, 4, '0, 1, 8'h00, 8'h00, 9, rpat, 0);
    doTxn("i2c read short reply", 4'h1, 20'h00050, 8, '0, 0, 8'h00, 8'h80, 3, rpat, 0);
    doTxn("read addr-only", 4'h9, 20'h12345, 0, '0, 0, 8'h00, 8'h00, 0, rpat, 0);
    doTxn("timeout status", 4'h9, 20'h00001, 2, '0, 0, 8'h01, 8'hF0, 2, rpat, 0);
    doTxn("flags status", 4'h8, 20'h00002, 3, pat, 0, 8'h02, 8'hF0, 0, '0, 0);
    doTxn("error status", 4'h1, 20'h00003, 4, '0, 0, 8'h03, 8'hF0, 4, rpat, 0);
    doTxn("other status ok", 4'h9, 20'h00004, 2, '0, 0, 8'h07, 8'h30, 2, rpat, 0);
    doTxn("write 13 rejected", 4'h8, 20'h00010, 13, pat, 0, 8'h00, 8'h00, 0, '0, 0);
    doTxn("read 17 rejected", 4'h9, 20'h00010, 17, '0, 0, 8'h00, 8'h00, 0, '0, 0);
    doTxn("unknown code", 4'hA, 20'h00010, 1, '0, 0, 8'h00, 8'h00, 0, '0, 0);
    doTxn("unknown code oversize", 4'hB, 20'h00010, 20, '0, 0, 8'h00, 8'h00, 0, '0, 0);
    doTxn("read with request offered while busy", 4'h9, 20'h0ABCD, 3, '0, 1, 8'h00, 8'h10, 3, rpat, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule